// File: doc/BRIEF.md
# Receive Link Supervisor

The block sits on one receive channel of a serial link. It picks the bit stream that reaches the clock and data recovery path: the primary serial input, the secondary serial input, or the channel's own transmit bit looped back inside the block. When loopback is on, the serial transmit output is held at logic 1 and both external inputs are ignored.

Three detectors qualify the chosen stream:

- A rate monitor counts rising edges of the recovered clock over a fixed window of reference-clock rising edges. It checks the count against the band set by a 2-bit speed code.
- A run-length monitor flags a stream that holds one value for 60 bits in a row.
- A watchdog flags a reference clock that has stopped toggling.

An external signal-level flag stands in for the analog amplitude detector.

A small state machine decides whether the recovery loop should track the incoming data or the local reference. An active-low fault output combines six conditions into one flag.

The state machine has three states:

- `ST_LOCAL`: the local clock is forced.
- `ST_HUNT`: the loop tracks the reference while the block waits for qualification.
- `ST_TRACK`: the loop tracks the data.

Its transitions are:

- `force_local`: from any state to `ST_LOCAL` while the synchronized use-local input is low.
- `release`: from `ST_LOCAL` to `ST_HUNT` once that input is high.
- `qualify`: from `ST_HUNT` to `ST_TRACK` when the stream qualifies.
- `disqualify`: from `ST_TRACK` to `ST_HUNT` when it no longer qualifies.

The loopback, input-select and use-local inputs each pass through two synchronizing flops. The flops reset to 0.

Top module: `rx_link_supervisor`

## Requirements
- R1: With loopback off, `rx_bit_out` carries `ser_primary` when `in_sel` is 1 and `ser_secondary` when `in_sel` is 0. There is one register stage after the two synchronizing flops on `in_sel`.
- R2: With loopback on, `rx_bit_out` carries `tx_bit`, the two external inputs have no effect, and `serial_out` is 1. With loopback off, `serial_out` equals `tx_bit`.
- R3: The speed code sets the rate band:
  - `00` is 195 to 400 MBd.
  - `01` is 400 to 800 MBd.
  - `10` is 800 to 1500 MBd.
  - `11` never passes.

  The count bounds are floor(band_edge * WIN / REF_RATE), and both bounds are inclusive.
- R4: The rate result changes only at the close of each window of WIN reference rising edges. It reads out of range from reset until the first window closes.
- R5: Density fails while the current run of equal received bits is RUN_LIMIT (60) long or longer. A run of 59 equal bits never fails, and the next transition clears the failure.
- R6: The reference is flagged absent once REF_TIMEOUT clock cycles pass with no edge on `ref_lvl`. The flag clears on the next edge.
- R7: With `det_en` high, the machine tracks data only when the signal level, rate and density are all valid. Otherwise it tracks the reference.
- R8: With `det_en` low, only the rate result decides between data and reference.
- R9: A low `use_local_n` forces `ST_LOCAL`. In that state `track_data` is 0 and `link_fault_n` is 0.
- R10: `link_fault_n` is 0 whenever any of these holds: rate out of band, `sig_ok` low, density failed, `rx_en` low, use-local active, or reference absent.
- R11: After reset, `track_data` is 0 and `link_fault_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_primary | input | 1 | Primary serial input bit |
| ser_secondary | input | 1 | Secondary serial input bit |
| tx_bit | input | 1 | Transmit serial bit of this channel |
| in_sel | input | 1 | 1 selects primary, 0 selects secondary (asynchronous) |
| loopback_en | input | 1 | Internal loopback enable (asynchronous) |
| use_local_n | input | 1 | Low forces local reference tracking (asynchronous) |
| det_en | input | 1 | Enables signal-level and density qualification |
| sig_ok | input | 1 | Signal amplitude valid from the analog detector |
| rx_en | input | 1 | Receive channel enabled |
| speed_code | input | 2 | Expected rate band code |
| ref_lvl | input | 1 | Sampled reference clock level |
| rec_lvl | input | 1 | Sampled recovered clock level |
| serial_out | output | 1 | Serial transmit output |
| rx_bit_out | output | 1 | Bit stream passed to the recovery path |
| track_data | output | 1 | 1 = track data, 0 = track reference |
| link_fault_n | output | 1 | Active-low link fault |

## Verification
The bench builds the block with its defaults: WIN = 16 and REF_RATE = 100, so the band bounds are 31..64, 64..128 and 128..240. The run limit is 60 and the watchdog limit is 64. The reference runs at 40 clock cycles per period, so a window is 640 cycles.

These small values make several sweeps short enough to run:

- all four speed codes against four recovered-clock periods, each about 10% or more from every bound;
- all 32 combinations of source bits, input select and loopback;
- all 16 combinations of the qualifying controls;
- the exact 59 and 60 run-length boundary;
- a stall and restart of the reference.

// File: rtl/rls_pkg.sv
package rls_pkg;

    typedef enum logic [1:0] {
        ST_LOCAL = 2'd0,
        ST_HUNT  = 2'd1,
        ST_TRACK = 2'd2
    } sup_state_t;

    typedef enum logic [1:0] {
        SPD_LOW  = 2'd0,
        SPD_MID  = 2'd1,
        SPD_HIGH = 2'd2,
        SPD_RSVD = 2'd3
    } speed_t;

    // lower band edge in MBd; reserved code gets an empty band
    function automatic int unsigned band_lo_mbd(input logic [1:0] code);
        unique case (code)
            SPD_LOW:  return 195;
            SPD_MID:  return 400;
            SPD_HIGH: return 800;
            default:  return 1;
        endcase
    endfunction

    function automatic int unsigned band_hi_mbd(input logic [1:0] code);
        unique case (code)
            SPD_LOW:  return 400;
            SPD_MID:  return 800;
            SPD_HIGH: return 1500;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/rls_sync.sv
module rls_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/rls_ref_watch.sv
module rls_ref_watch #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_lvl,
    output logic ref_rise,
    output logic ref_lost
);
    localparam int WD_W = $clog2(TIMEOUT + 1);

    logic            ref_d;
    logic [WD_W-1:0] wd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d <= 1'b0;
            wd    <= '0;
        end else begin
            ref_d <= ref_lvl;
            if (ref_lvl != ref_d)
                wd <= '0;
            else if (wd != WD_W'(TIMEOUT))
                wd <= wd + 1'b1;
        end
    end

    assign ref_rise = ref_lvl & ~ref_d;
    assign ref_lost = (wd == WD_W'(TIMEOUT));
endmodule

// File: rtl/rls_rate_mon.sv
module rls_rate_mon
    import rls_pkg::*;
#(
    parameter int WIN      = 16,
    parameter int REF_RATE = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_rise,
    input  logic       rec_lvl,
    input  logic [1:0] speed_code,
    output logic       rate_ok
);
    localparam int MAX_CNT = (1500 * WIN) / REF_RATE;
    localparam int CNT_W   = $clog2(2 * MAX_CNT + 2);
    localparam int WIN_W   = (WIN > 1) ? $clog2(WIN) : 1;

    logic             rec_d;
    logic             rec_rise;
    logic [CNT_W-1:0] rec_cnt;
    logic [CNT_W-1:0] total;
    logic [WIN_W-1:0] win_cnt;
    int unsigned      lo_cnt, hi_cnt;

    assign rec_rise = rec_lvl & ~rec_d;
    assign total    = (rec_cnt == '1) ? rec_cnt : rec_cnt + CNT_W'(rec_rise);
    assign lo_cnt   = (band_lo_mbd(speed_code) * WIN) / REF_RATE;
    assign hi_cnt   = (band_hi_mbd(speed_code) * WIN) / REF_RATE;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_d   <= 1'b0;
            rec_cnt <= '0;
            win_cnt <= '0;
            rate_ok <= 1'b0;
        end else begin
            rec_d <= rec_lvl;
            if (ref_rise && (win_cnt == WIN_W'(WIN - 1))) begin
                rate_ok <= (32'(total) >= lo_cnt) && (32'(total) <= hi_cnt);
                rec_cnt <= '0;
                win_cnt <= '0;
            end else begin
                rec_cnt <= total;
                if (ref_rise)
                    win_cnt <= win_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rls_density_mon.sv
module rls_density_mon #(
    parameter int RUN_LIMIT = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic dens_ok
);
    localparam int RUN_W = $clog2(RUN_LIMIT + 1);

    logic             bit_d;
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_d <= 1'b0;
            run   <= '0;
        end else begin
            bit_d <= bit_in;
            if (bit_in != bit_d)
                run <= RUN_W'(1);
            else if (run != RUN_W'(RUN_LIMIT))
                run <= run + 1'b1;
        end
    end

    assign dens_ok = (run != RUN_W'(RUN_LIMIT));
endmodule

// File: rtl/rx_link_supervisor.sv
module rx_link_supervisor
    import rls_pkg::*;
#(
    parameter int WIN         = 16,
    parameter int REF_RATE    = 100,
    parameter int RUN_LIMIT   = 60,
    parameter int REF_TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_primary,
    input  logic       ser_secondary,
    input  logic       tx_bit,
    input  logic       in_sel,
    input  logic       loopback_en,
    input  logic       use_local_n,
    input  logic       det_en,
    input  logic       sig_ok,
    input  logic       rx_en,
    input  logic [1:0] speed_code,
    input  logic       ref_lvl,
    input  logic       rec_lvl,
    output logic       serial_out,
    output logic       rx_bit_out,
    output logic       track_data,
    output logic       link_fault_n
);
    localparam int NCTL = 3;

    logic [NCTL-1:0] ctl_s;
    logic            lpbk_s, sel_s, ulc_s;
    logic            ref_rise, ref_lost;
    logic            rate_ok, dens_ok;
    logic            rx_bit_q;
    logic            qualified;
    sup_state_t      state, state_nx;

    rls_sync #(.W(NCTL), .RST_VAL('0)) u_sync (
        .clk(clk), .rst(rst),
        .d({loopback_en, in_sel, use_local_n}),
        .q(ctl_s)
    );
    assign {lpbk_s, sel_s, ulc_s} = ctl_s;

    rls_ref_watch #(.TIMEOUT(REF_TIMEOUT)) u_ref (
        .clk(clk), .rst(rst), .ref_lvl(ref_lvl),
        .ref_rise(ref_rise), .ref_lost(ref_lost)
    );

    rls_rate_mon #(.WIN(WIN), .REF_RATE(REF_RATE)) u_rate (
        .clk(clk), .rst(rst), .ref_rise(ref_rise), .rec_lvl(rec_lvl),
        .speed_code(speed_code), .rate_ok(rate_ok)
    );

    rls_density_mon #(.RUN_LIMIT(RUN_LIMIT)) u_dens (
        .clk(clk), .rst(rst), .bit_in(rx_bit_q), .dens_ok(dens_ok)
    );

    // receive source mux, registered
    always_ff @(posedge clk) begin
        if (rst)
            rx_bit_q <= 1'b0;
        else if (lpbk_s)
            rx_bit_q <= tx_bit;
        else
            rx_bit_q <= sel_s ? ser_primary : ser_secondary;
    end

    assign qualified = det_en ? (sig_ok & rate_ok & dens_ok) : rate_ok;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_LOCAL;
        else
            state <= state_nx;
    end

    // transitions: force_local, release, qualify, disqualify
    always_comb begin
        state_nx = state;
        if (!ulc_s) begin
            state_nx = ST_LOCAL;
        end else begin
            unique case (state)
                ST_LOCAL: state_nx = ST_HUNT;
                ST_HUNT:  if (qualified)  state_nx = ST_TRACK;
                ST_TRACK: if (!qualified) state_nx = ST_HUNT;
                default:  state_nx = ST_LOCAL;
            endcase
        end
    end

    // outputs
    always_comb begin
        track_data   = (state == ST_TRACK);
        serial_out   = lpbk_s ? 1'b1 : tx_bit;
        rx_bit_out   = rx_bit_q;
        link_fault_n = ~(~rate_ok | ~sig_ok | ~dens_ok | ~rx_en | ~ulc_s | ref_lost);
    end
endmodule

// File: rtl/rx_link_supervisor_chk.sv
module rx_link_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic loopback_en,
    input logic use_local_n,
    input logic det_en,
    input logic sig_ok,
    input logic serial_out,
    input logic track_data,
    input logic link_fault_n,
    input logic rate_ok,
    input logic dens_ok
);
    logic [2:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)
            cyc <= '0;
        else if (cyc != 3'd4)
            cyc <= cyc + 1'b1;
    end

    // R2
    lpbk_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd3 && loopback_en && $past(loopback_en) && $past(loopback_en, 2))
        |-> serial_out);

    // R9
    local_force_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4 && !use_local_n && !$past(use_local_n) && !$past(use_local_n, 2)
         && !$past(use_local_n, 3)) |-> (!track_data && !link_fault_n));

    // R7
    sig_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd1 && track_data && $past(det_en)) |-> $past(sig_ok));

    // R7
    dens_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd1 && track_data && $past(det_en)) |-> $past(dens_ok));

    // R8
    rate_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd1 && track_data) |-> $past(rate_ok));
endmodule

bind rx_link_supervisor rx_link_supervisor_chk u_chk (
    .clk(clk), .rst(rst), .loopback_en(loopback_en), .use_local_n(use_local_n),
    .det_en(det_en), .sig_ok(sig_ok), .serial_out(serial_out),
    .track_data(track_data), .link_fault_n(link_fault_n),
    .rate_ok(rate_ok), .dens_ok(dens_ok)
);

// File: tb/rx_link_supervisor_bench.sv
module rx_link_supervisor_bench;
    localparam int WIN = 16, REF_RATE = 100, RUN_LIMIT = 60, REF_TIMEOUT = 64;
    localparam int REF_HALF = 20;

    logic clk = 1'b0, rst = 1'b1;
    logic prim_man = 0, tgl_bit = 0, tog_en = 1;
    logic ser_secondary = 0, tx_bit = 0, in_sel = 1, loopback_en = 0;
    logic use_local_n = 1, det_en = 1, sig_ok = 1, rx_en = 1;
    logic [1:0] speed_code = 2'd0;
    logic ref_lvl = 0, rec_lvl = 0, ref_run = 1;
    int   rec_half = 7, ref_cnt = 0, rec_cnt = 0;
    logic ser_primary, serial_out, rx_bit_out, track_data, link_fault_n;
    logic mon_en = 0, seen_fault = 0;
    int   n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    assign ser_primary = tog_en ? tgl_bit : prim_man;

    always @(negedge clk) begin
        tgl_bit <= ~tgl_bit;
        if (ref_run) begin
            if (ref_cnt == REF_HALF - 1) begin ref_cnt <= 0; ref_lvl <= ~ref_lvl; end
            else ref_cnt <= ref_cnt + 1;
        end
        if (rec_cnt >= rec_half - 1) begin rec_cnt <= 0; rec_lvl <= ~rec_lvl; end
        else rec_cnt <= rec_cnt + 1;
        if (mon_en && !link_fault_n) seen_fault <= 1'b1;
    end

    rx_link_supervisor #(.WIN(WIN), .REF_RATE(REF_RATE), .RUN_LIMIT(RUN_LIMIT),
                         .REF_TIMEOUT(REF_TIMEOUT)) u_rx_link_supervisor (
        .clk(clk), .rst(rst), .ser_primary(ser_primary), .ser_secondary(ser_secondary),
        .tx_bit(tx_bit), .in_sel(in_sel), .loopback_en(loopback_en),
        .use_local_n(use_local_n), .det_en(det_en), .sig_ok(sig_ok), .rx_en(rx_en),
        .speed_code(speed_code), .ref_lvl(ref_lvl), .rec_lvl(rec_lvl),
        .serial_out(serial_out), .rx_bit_out(rx_bit_out), .track_data(track_data),
        .link_fault_n(link_fault_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic in_band(input int code, input int half);
        int cnt, lo, hi;
        cnt = (WIN * 2 * REF_HALF) / (2 * half);
        case (code)
            0: begin lo = 195 * WIN / REF_RATE; hi = 400 * WIN / REF_RATE; end
            1: begin lo = 400 * WIN / REF_RATE; hi = 800 * WIN / REF_RATE; end
            2: begin lo = 800 * WIN / REF_RATE; hi = 1500 * WIN / REF_RATE; end
            default: begin lo = 1; hi = 0; end
        endcase
        return (cnt >= lo) && (cnt <= hi);
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        int halves[4] = '{15, 7, 4, 2};
        wait_n(5);
        rst = 1'b0;
        wait_n(3);
        // R11 / R4: reset state, no window closed yet
        chk("R11 track after reset", track_data, 1'b0);
        chk("R4 fault before first window", link_fault_n, 1'b0);

        // R3 / R4 / R7: speed code against recovered rate
        for (int c = 0; c < 4; c++) begin
            for (int h = 0; h < 4; h++) begin
                speed_code = 2'(c);
                rec_half = halves[h];
                wait_n(2000);
                chk("R3 rate band fault", link_fault_n, in_band(c, halves[h]));
                chk("R7 rate band track", track_data, in_band(c, halves[h]));
            end
        end
        speed_code = 2'd0; rec_half = 7;
        wait_n(2000);

        // R1 / R2: exhaustive source selection
        tog_en = 0;
        for (int m = 0; m < 32; m++) begin
            prim_man = m[0]; ser_secondary = m[1]; tx_bit = m[2];
            in_sel = m[3]; loopback_en = m[4];
            wait_n(4);
            if (m[4]) begin
                chk("R2 loopback routes tx", rx_bit_out, m[2]);
                chk("R2 serial out forced", serial_out, 1'b1);
            end else begin
                chk("R1 input select", rx_bit_out, m[3] ? m[0] : m[1]);
                chk("R2 serial out passes tx", serial_out, m[2]);
            end
        end
        loopback_en = 0; in_sel = 1; tx_bit = 0;
        tog_en = 1;
        wait_n(20);

        // R5: run length boundary 59 vs 60
        for (int L = 59; L <= 60; L++) begin
            tog_en = 0; prim_man = tgl_bit;
            wait_n(6);
            for (int k = 0; k < 8; k++) begin prim_man = ~prim_man; wait_n(1); end
            seen_fault = 0; mon_en = 1;
            prim_man = ~prim_man;
            wait_n(L);
            prim_man = ~prim_man;
            wait_n(6);
            mon_en = 0;
            chk(L == 60 ? "R5 run of 60 fails" : "R5 run of 59 passes", seen_fault, L == 60);
            tog_en = 1;
            wait_n(10);
        end

        // R5 / R7 / R8 / R10: long constant stream
        tog_en = 0;
        wait_n(150);
        chk("R10 density fault", link_fault_n, 1'b0);
        chk("R7 density blocks track", track_data, 1'b0);
        det_en = 0;
        wait_n(4);
        chk("R8 rate alone decides", track_data, 1'b1);
        chk("R10 fault regardless of det_en", link_fault_n, 1'b0);
        det_en = 1; tog_en = 1;
        wait_n(10);
        chk("R5 transition clears", link_fault_n, 1'b1);
        chk("R7 tracking resumes", track_data, 1'b1);

        // R7 / R8 / R9 / R10: exhaustive control sweep
        for (int m = 0; m < 16; m++) begin
            det_en = m[0]; sig_ok = m[1]; use_local_n = m[2]; rx_en = m[3];
            wait_n(8);
            chk(m[2] ? "R7 R8 track decision" : "R9 local forces ref", track_data,
                m[2] && (m[0] ? m[1] : 1'b1));
            chk("R10 fault summary", link_fault_n, m[1] && m[2] && m[3]);
        end
        det_en = 1; sig_ok = 1; use_local_n = 1; rx_en = 1;
        wait_n(10);

        // R6: reference stall
        ref_run = 0;
        wait_n(40);
        chk("R6 not flagged early", link_fault_n, 1'b1);
        wait_n(60);
        chk("R6 reference lost", link_fault_n, 1'b0);
        ref_run = 1;
        wait_n(2000);
        chk("R6 reference restored", link_fault_n, 1'b1);

        finish_run();
    end
endmodule